// File: doc/BRIEF.md
# Serial Register-Bank Slave

This block is a synchronous serial slave that lets an external host read and write an internal bank of up to 32 registers over a four-wire link: select (active low), serial clock, data in and data out. Every transaction opens with a falling select line. The host sends a command byte that carries a direction flag and a register address. One or more data bytes follow, most significant byte first. All four link signals are asynchronous to the block. They are brought into the system clock domain through two-flop synchronizers, and their edges are found there.

Toward the chip the block has a simple parallel port. It gives a register address and a one-cycle write strobe with right-justified write data. It takes back the read data of the addressed register and that register's byte length (1 to 5). The length lookup lets a 40-bit accumulator and an 8-bit control register share one protocol. Reads capture the whole register once, when the command byte is complete. The data-out line is driven only while read data is being shifted out.

The controller is one state machine with these states:
- `ST_IDLE` waits for select to fall, then moves to `ST_CMD`.
- `ST_CMD` shifts in eight command bits and moves to `ST_LOAD`.
- `ST_LOAD` spends one cycle latching the length and the read snapshot, then moves to `ST_WDATA` or `ST_RDATA`.
- `ST_WDATA` shifts in write data until the last bit and moves to `ST_COMMIT`.
- `ST_RDATA` shifts out read data until the last bit and moves to `ST_DONE`.
- `ST_COMMIT` issues the write strobe and moves to `ST_DONE`.
- `ST_DONE` ignores the serial clock until select rises.

A high select returns every state to `ST_IDLE`.

Top module: `serial_regbank_slave`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 a read. Bits 4:0 give the register address. Bits 6:5 are sent as zero.
- R2: The number of data bytes is taken from `reg_len` for the addressed register. A value of 0 is treated as 1 byte and any value above 5 as 5 bytes.
- R3: Data-in is sampled on each falling edge of the serial clock. Data bytes go most significant byte first, and each byte goes bit 7 first.
- R4: A write produces exactly one single-cycle `reg_wr_en` pulse, after the final data bit is received. `reg_addr` holds the address, and `reg_wr_data` holds the received bytes right-justified with zeros above them.
- R5: During a read, the data-out bit changes only after a rising edge of the serial clock. The first data bit (the MSB of the register's top byte) is launched by the first rising edge after the command byte.
- R6: A read returns the register value present when the command byte completed. Later changes to the register do not affect the bytes being shifted out.
- R7: `ser_dout_oe` is high only in the read data phase. It drops after the falling edge that ends the read data, and within one cycle of the synchronized select being high.
- R8: Select rising before the last bit aborts the transaction: no write strobe is issued and the bit counter is cleared, so the next transaction decodes normally.
- R9: After reset, `ser_dout_oe` and `reg_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, idle high |
| ser_sel_n | input | 1 | Active-low select from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host, high-impedance when not enabled |
| ser_dout_oe | output | 1 | Drive enable for `ser_dout` |
| reg_addr | output | 5 | Address of the register being accessed |
| reg_len | input | 3 | Byte length of the register at `reg_addr` |
| reg_rd_data | input | 40 | Current value of the register at `reg_addr` |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | 40 | Write value, right-justified |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, up to 5 data bytes and two synchronizer stages. With these values every one of the 32 addresses can be written and then read back, which covers every byte length from 1 to 5 and the clamping of length codes 0 and 7. Arithmetically generated patterns give each byte a distinct value, so byte-order and bit-order errors show up in the readback. The serial clock runs at 16 system cycles per bit. This leaves room to inject a register change in the middle of a read and to raise select in the middle of a command byte or a data byte.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_LOAD,
        ST_WDATA,
        ST_RDATA,
        ST_COMMIT,
        ST_DONE
    } srb_state_e;
endpackage

// File: rtl/serial_regbank_sync.sv
module serial_regbank_sync #(
    parameter int              N       = 3,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/serial_regbank_ctrl.sv
module serial_regbank_ctrl
    import serial_regbank_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_BYTES = 5,
    parameter int DATA_W    = MAX_BYTES * 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1),
    parameter int CNT_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              din_s,
    output logic              dout_q,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [LEN_W-1:0]  reg_len,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data
);
    srb_state_e        state_q, state_d;
    logic              sclk_p, csn_p;
    logic              sclk_rise, sclk_fall, cs_fall;
    logic [6:0]        sh_q;
    logic [7:0]        cmd_w;
    logic [CNT_W-1:0]  cnt_q, last_idx;
    logic [LEN_W-1:0]  nbytes_q, len_eff;
    logic [ADDR_W-1:0] addr_q;
    logic              dir_wr_q;
    logic [DATA_W-1:0] wbuf_q, rbuf_q;
    logic              last_bit;

    assign sclk_rise = sclk_s & ~sclk_p;
    assign sclk_fall = ~sclk_s & sclk_p;
    assign cs_fall   = ~csn_s & csn_p;
    assign cmd_w     = {sh_q, din_s};
    assign last_idx  = CNT_W'({nbytes_q, 3'b000}) - CNT_W'(1);
    assign last_bit  = (cnt_q == last_idx);

    always_comb begin
        if (reg_len == '0)                     len_eff = LEN_W'(1);
        else if (reg_len > LEN_W'(MAX_BYTES))  len_eff = LEN_W'(MAX_BYTES);
        else                                   len_eff = reg_len;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_p  <= 1'b1;
            csn_p   <= 1'b1;
        end else begin
            state_q <= state_d;
            sclk_p  <= sclk_s;
            csn_p   <= csn_s;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_CMD;
            ST_CMD:    if (csn_s) state_d = ST_IDLE;
                       else if (sclk_fall && cnt_q == CNT_W'(7)) state_d = ST_LOAD;
            ST_LOAD:   if (csn_s) state_d = ST_IDLE;
                       else state_d = dir_wr_q ? ST_WDATA : ST_RDATA;
            ST_WDATA:  if (csn_s) state_d = ST_IDLE;
                       else if (sclk_fall && last_bit) state_d = ST_COMMIT;
            ST_RDATA:  if (csn_s) state_d = ST_IDLE;
                       else if (sclk_fall && last_bit) state_d = ST_DONE;
            ST_COMMIT: state_d = csn_s ? ST_IDLE : ST_DONE;
            ST_DONE:   if (csn_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            nbytes_q <= LEN_W'(1);
            addr_q   <= '0;
            dir_wr_q <= 1'b0;
            wbuf_q   <= '0;
            rbuf_q   <= '0;
            dout_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_CMD: begin
                    if (sclk_fall) begin
                        sh_q  <= cmd_w[6:0];
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(7)) begin
                            addr_q   <= cmd_w[ADDR_W-1:0];
                            dir_wr_q <= cmd_w[7];
                        end
                    end
                end
                ST_LOAD: begin
                    nbytes_q <= len_eff;
                    cnt_q    <= '0;
                    wbuf_q   <= '0;
                    dout_q   <= 1'b0;
                    rbuf_q   <= reg_rd_data << (8 * (MAX_BYTES - int'(len_eff)));
                end
                ST_WDATA: begin
                    if (sclk_fall) begin
                        wbuf_q <= {wbuf_q[DATA_W-2:0], din_s};
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                ST_RDATA: begin
                    if (sclk_rise) begin
                        dout_q <= rbuf_q[DATA_W-1];
                        rbuf_q <= {rbuf_q[DATA_W-2:0], 1'b0};
                    end
                    if (sclk_fall) cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dout_oe     = (state_q == ST_RDATA);
        reg_wr_en   = (state_q == ST_COMMIT);
        reg_addr    = addr_q;
        reg_wr_data = wbuf_q;
    end

    // R4
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R5
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && !sclk_rise) |=> $stable(dout_q));
    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !dout_oe);
    // R8
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA && csn_s) |=> !reg_wr_en);
    // R1
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_fall) |=> (state_q == ST_CMD && cnt_q == '0));
endmodule

// File: rtl/serial_regbank_slave.sv
module serial_regbank_slave #(
    parameter int ADDR_W      = 5,
    parameter int MAX_BYTES   = 5,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = MAX_BYTES * 8,
    localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [LEN_W-1:0]  reg_len,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data
);
    logic [2:0] sync_lvl;
    logic       dout_bit;

    serial_regbank_sync #(
        .N      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({ser_din, ser_sel_n, ser_clk}),
        .sync_out(sync_lvl)
    );

    serial_regbank_ctrl #(
        .ADDR_W   (ADDR_W),
        .MAX_BYTES(MAX_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_lvl[0]),
        .csn_s      (sync_lvl[1]),
        .din_s      (sync_lvl[2]),
        .dout_q     (dout_bit),
        .dout_oe    (ser_dout_oe),
        .reg_addr   (reg_addr),
        .reg_len    (reg_len),
        .reg_rd_data(reg_rd_data),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_data(reg_wr_data)
    );

    assign ser_dout = ser_dout_oe ? dout_bit : 1'bz;
endmodule

// File: tb/serial_regbank_slave_tb.sv
module serial_regbank_slave_tb;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_sel_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic        ser_dout_oe;
    logic [4:0]  reg_addr;
    logic [2:0]  reg_len;
    logic [39:0] reg_rd_data;
    logic        reg_wr_en;
    logic [39:0] reg_wr_data;

    logic [39:0] mem [32];
    logic        poke_en = 1'b0;
    logic [4:0]  poke_addr = '0;
    logic [39:0] poke_val = '0;
    int          wr_pulses = 0;
    int          total = 0;
    int          bad = 0;
    int          oe_gaps = 0;

    always #4 clk = ~clk;

    serial_regbank_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .reg_addr(reg_addr), .reg_len(reg_len), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
    );

    function automatic int len_code(int a);
        if (a == 31) return 0;
        if (a == 30) return 7;
        return (a % 5) + 1;
    endfunction

    function automatic int len_eff(int a);
        int c = len_code(a);
        if (c == 0) return 1;
        if (c > 5) return 5;
        return c;
    endfunction

    function automatic logic [39:0] mask_of(int nb);
        return (nb >= 5) ? 40'hFF_FFFF_FFFF : ((40'd1 << (nb * 8)) - 40'd1);
    endfunction

    function automatic logic [39:0] pattern(int a, int salt);
        logic [39:0] v = '0;
        for (int k = 0; k < 5; k++)
            v[k*8 +: 8] = 8'((a * 37 + k * 53 + salt * 11 + 7) % 256);
        return v;
    endfunction

    assign reg_len     = 3'(len_code(int'(reg_addr)));
    assign reg_rd_data = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            wr_pulses     <= wr_pulses + 1;
        end else if (poke_en) begin
            mem[poke_addr] <= poke_val;
        end
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // abort_at: bit index at which select is raised (-1: run to completion)
    task automatic xact(input bit wr, input int a, input int nb, input logic [39:0] wv,
                        input int abort_at, input bit poke, input logic [39:0] pv,
                        output logic [39:0] rv);
        logic [7:0] cmd;
        int         nbits;
        cmd   = {wr, 2'b00, 5'(a)};
        nbits = 8 + nb * 8;
        rv    = '0;
        ser_sel_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < nbits; i++) begin
            if (i == abort_at) break;
            if (i == 8 && poke) begin
                poke_addr = 5'(a);
                poke_val  = pv;
                poke_en   = 1'b1;
                wait_n(1);
                poke_en   = 1'b0;
            end
            ser_din = (i < 8) ? cmd[7 - i] : wv[nb * 8 - 1 - (i - 8)];
            wait_n(H);
            if (i >= 8 && !wr) begin
                if (!ser_dout_oe) oe_gaps++;
                rv = {rv[38:0], ser_dout};
            end
            ser_clk = 1'b0;
            wait_n(H);
            ser_clk = 1'b1;
        end
        wait_n(H);
        ser_sel_n = 1'b1;
        wait_n(2 * H);
    endtask

    initial begin
        logic [39:0] rv;
        logic [39:0] exp_v;
        int          nb;
        int          w0;
        for (int a = 0; a < 32; a++) mem[a] = '0;
        wait_n(5);
        // R9: reset state
        chk("R9 oe after reset", 40'(ser_dout_oe), 40'd0);
        chk("R9 wr_en after reset", 40'(reg_wr_en), 40'd0);
        rst_n = 1'b1;
        wait_n(5);

        // R1 R2 R3 R4: write every address with its own length
        for (int a = 0; a < 32; a++) begin
            nb = len_eff(a);
            w0 = wr_pulses;
            xact(1'b1, a, nb, pattern(a, 1), -1, 1'b0, '0, rv);
            chk($sformatf("R4 write pulses addr %0d", a), 40'(wr_pulses - w0), 40'd1);
            chk($sformatf("R2 R3 write value addr %0d", a), mem[a], pattern(a, 1) & mask_of(nb));
        end

        // R1 R5 R7: read every address back
        for (int a = 0; a < 32; a++) begin
            nb = len_eff(a);
            w0 = wr_pulses;
            xact(1'b0, a, nb, '0, -1, 1'b0, '0, rv);
            chk($sformatf("R5 read value addr %0d", a), rv, pattern(a, 1) & mask_of(nb));
            chk($sformatf("R1 read makes no write addr %0d", a), 40'(wr_pulses - w0), 40'd0);
            chk($sformatf("R7 oe released addr %0d", a), 40'(ser_dout_oe), 40'd0);
        end
        chk("R7 oe during read data", 40'(oe_gaps), 40'd0);

        // R6: register changes after the command byte; old value read out
        exp_v = mem[4];
        xact(1'b0, 4, 5, '0, -1, 1'b1, 40'hA5_C3_3C_5A_0F, rv);
        chk("R6 snapshot value", rv, exp_v);
        chk("R6 poke applied", mem[4], 40'hA5_C3_3C_5A_0F);

        // R8: abort mid data byte of a write
        exp_v = mem[3];
        w0 = wr_pulses;
        xact(1'b1, 3, 4, pattern(3, 9), 8 + 8 + 3, 1'b0, '0, rv);
        chk("R8 no write on abort", 40'(wr_pulses - w0), 40'd0);
        chk("R8 register unchanged", mem[3], exp_v);

        // R8: abort mid command byte, then a clean read
        xact(1'b1, 9, 5, '0, 4, 1'b0, '0, rv);
        chk("R8 no write on command abort", 40'(wr_pulses - w0), 40'd0);
        xact(1'b0, 3, 4, '0, -1, 1'b0, '0, rv);
        chk("R8 clean read after abort", rv, exp_v & mask_of(4));

        // R2: clamped lengths re-read with new data
        xact(1'b1, 31, 1, 40'h00_0000_00C7, -1, 1'b0, '0, rv);
        xact(1'b0, 31, 1, '0, -1, 1'b0, '0, rv);
        chk("R2 length code 0 as one byte", rv, 40'h00_0000_00C7);
        xact(1'b1, 30, 5, 40'h81_42_24_18_E7, -1, 1'b0, '0, rv);
        xact(1'b0, 30, 5, '0, -1, 1'b0, '0, rv);
        chk("R2 length code 7 as five bytes", rv, 40'h81_42_24_18_E7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule